// File: doc/BRIEF.md
# SPI Slave Byte Transceiver

This block is the slave end of a four-wire synchronous serial link. Each frame moves one byte in each direction, most significant bit first. The master drives the serial clock, the select line and the data line into the slave. The slave returns its data on its output line.

Two configuration inputs choose the clock idle level and the clock phase, so all four classic modes are covered. The serial clock, select and data inputs are resynchronized into the system clock domain, and all edge detection happens after that. The system clock must run at least eight times faster than the serial clock.

The local side sees three things. A received byte arrives with a one-cycle valid strobe. A one-deep transmit holding buffer is filled through a load strobe, and a room flag shows when the buffer can take a byte. A byte is taken from the buffer when a frame starts. When the buffer is empty, the slave sends all ones.

Top module: `spi_byte_slave`

The controller has four named states:

- ST_IDLE: the slave is deselected.
- ST_ARMED: phase 1 only. Select is low and the slave waits for the first clock edge of a byte.
- ST_SHIFT: a byte is in flight.
- ST_HOLD: phase 0 only. The byte is complete and the slave waits for select to rise.

The transitions are:

- IDLE to SHIFT when select falls with phase 0. The transmit byte is loaded at this point.
- IDLE to ARMED when select falls with phase 1.
- ARMED to SHIFT on a leading clock edge. The transmit byte is loaded at this point.
- SHIFT to HOLD on the eighth capture with phase 0.
- SHIFT to ARMED on the eighth capture with phase 1.
- Any state to IDLE whenever the synchronized select is high.

## Requirements
- R1: A full frame yields exactly one rx_valid pulse, one system clock long. rx_data holds the eight bits seen on spi_mosi, the first bit being bit 7.
- R2: The transmit byte is shifted out on spi_miso with bit 7 first and bit 0 last.
- R3: cfg_cpol gives the clock idle level (0 low, 1 high). A leading edge is the edge that leaves the idle level; a trailing edge is the edge that returns to it.
- R4: With cfg_cpha=0, a select fall puts bit 7 on spi_miso before the first clock edge. The slave captures data on leading edges and shifts on trailing edges.
- R5: With cfg_cpha=1, the first leading edge starts the byte and drives bit 7. The slave captures data on trailing edges and shifts on the later leading edges.
- R6: With cfg_cpha=0, once eight bits have been captured, further clock edges while select stays low produce no rx_valid, and spi_miso stays at 1. A new byte needs select to rise and fall again.
- R7: With cfg_cpha=1, select may stay low between bytes. Back-to-back bytes are each received, and each sends the byte that was pending when it started.
- R8: While spi_cs_n is high, spi_miso is 1. Clock edges have no effect there: no rx_valid, and the pending transmit byte is kept.
- R9: If select rises before the eighth capture, the partial byte is dropped and no rx_valid is produced. The next frame starts from bit 7.
- R10: tx_room is 1 when the holding buffer is empty. tx_load with tx_room=1 stores tx_data and drops tx_room on the next cycle. tx_load with tx_room=0 is ignored. The buffer empties when a byte starts.
- R11: A byte that starts with an empty holding buffer sends 0xFF.
- R12: During and after reset: rx_valid=0, rx_data=0x00, spi_miso=1 and tx_room=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| spi_sck | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, 1 when idle |
| rx_data | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |
| tx_data | input | 8 | Byte offered to the holding buffer |
| tx_load | input | 1 | Load strobe for tx_data |
| tx_room | output | 1 | Holding buffer is empty |

## Verification
Some properties are checked on every cycle:

- the strobe is one cycle wide;
- spi_miso is idle and no strobe appears once select has been high for a few cycles;
- a strobe is never produced out of a deselected synchronizer state;
- an accepted load always clears the room flag;
- the phase-0 hold state never leaks a strobe.

Other properties depend on a master driving real frames, so only the bench scenarios can show them:

- bit order in both directions across all four modes;
- the all-ones fill;
- ignored loads;
- back-to-back phase-1 bytes;
- restart after an aborted frame.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } slv_state_e;

endpackage

// File: rtl/spi_sync_bits.sv
module spi_sync_bits #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[s] <= rst_val;
            end else if (s == 0) begin
                stg[s] <= d_in;
            end else begin
                stg[s] <= stg[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/spi_edge_sel.sv
module spi_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_ev,
    output logic shift_ev
);

    logic sck_d;
    logic rise_ev;
    logic fall_ev;
    logic lead_ev;
    logic trail_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
        end
    end

    always_comb begin
        rise_ev  = sck_s & ~sck_d;
        fall_ev  = ~sck_s & sck_d;
        // a leading edge leaves the idle level
        lead_ev  = cpol ? fall_ev : rise_ev;
        trail_ev = cpol ? rise_ev : fall_ev;
        sample_ev = cpha ? trail_ev : lead_ev;
        shift_ev  = cpha ? lead_ev : trail_ev;
    end

endmodule

// File: rtl/spi_tx_buffer.sv
module spi_tx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              room,
    output logic [DATA_W-1:0] next_byte
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept = load & ~full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept) begin
                full_q <= 1'b1;
                data_q <= load_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign room      = ~full_q;
    assign next_byte = full_q ? data_q : '1;

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spi_slave_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_room
);

    localparam int                CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

    slv_state_e        state_q, state_d;
    logic [2:0]        sync_q;
    logic              sck_s, cs_s, mosi_s;
    logic              sample_ev, shift_ev;
    logic              start_tx, cap, shf, done;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rx_sr_q, tx_sr_q, rx_data_q, next_byte;
    logic              rx_valid_q;

    spi_sync_bits #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b010),
        .d_in    ({spi_sck, spi_cs_n, spi_mosi}),
        .q_out   (sync_q)
    );
    assign {sck_s, cs_s, mosi_s} = sync_q;

    spi_edge_sel edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev)
    );

    spi_tx_buffer #(.DATA_W(DATA_W)) txbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (tx_data),
        .take      (start_tx),
        .room      (tx_room),
        .next_byte (next_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and per-cycle controls
    always_comb begin
        state_d  = state_q;
        start_tx = 1'b0;
        cap      = 1'b0;
        shf      = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_s) begin
                    if (cfg_cpha) begin
                        state_d = ST_ARMED;
                    end else begin
                        state_d  = ST_SHIFT;
                        start_tx = 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (cs_s) begin
                    state_d = ST_IDLE;
                end else if (shift_ev) begin
                    state_d  = ST_SHIFT;
                    start_tx = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cs_s) begin
                    state_d = ST_IDLE;
                end else if (sample_ev) begin
                    cap = 1'b1;
                    if (cnt_q == LAST) begin
                        done    = 1'b1;
                        state_d = cfg_cpha ? ST_ARMED : ST_HOLD;
                    end
                end else if (shift_ev) begin
                    shf = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cs_s) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rx_sr_q    <= '0;
            tx_sr_q    <= '1;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= done;
            if (start_tx || state_d == ST_IDLE) begin
                cnt_q <= '0;
            end else if (cap) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cap) begin
                rx_sr_q <= {rx_sr_q[DATA_W-2:0], mosi_s};
            end
            if (done) begin
                rx_data_q <= {rx_sr_q[DATA_W-2:0], mosi_s};
            end
            if (start_tx) begin
                tx_sr_q <= next_byte;
            end else if (shf) begin
                tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b1};
            end
        end
    end

    // outputs
    always_comb begin
        spi_miso = (state_q == ST_SHIFT) ? tx_sr_q[DATA_W-1] : 1'b1;
        rx_data  = rx_data_q;
        rx_valid = rx_valid_q;
    end

endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk
    import spi_slave_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       rx_valid,
    input logic       tx_load,
    input logic       tx_room,
    input logic       cs_s,
    input slv_state_e state_q
);

    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> spi_miso);

    p_no_valid_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !rx_valid);

    p_valid_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(cs_s));

    p_room_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_load && tx_room) |-> !tx_room);

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> !rx_valid);

    p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q == ST_HOLD || state_q == ST_IDLE));

endmodule

bind spi_byte_slave spi_byte_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .rx_valid (rx_valid),
    .tx_load  (tx_load),
    .tx_room  (tx_room),
    .cs_s     (cs_s),
    .state_q  (state_q)
);

// File: tb/spi_byte_slave_tb_top.sv
module spi_byte_slave_tb_top;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic       tx_room;

    int         checks = 0;
    int         fails = 0;
    int         vcount = 0;
    logic [7:0] last_rx = 8'h00;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    spi_byte_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_load(tx_load), .tx_room(tx_room)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount  = vcount + 1;
            last_rx = rx_data;
        end
    end

    // {cpol, cpha, master byte, slave byte}
    localparam logic [17:0] VEC [8] = '{
        {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h5A, 8'hC3},
        {2'b10, 8'h81, 8'h7E}, {2'b11, 8'h7E, 8'h81},
        {2'b00, 8'h01, 8'h80}, {2'b01, 8'h80, 8'h01},
        {2'b10, 8'hF0, 8'h0F}, {2'b11, 8'h0F, 8'hF0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cfg_cpol = pol;
        cfg_cpha = pha;
        spi_sck  = pol;
        wait_clk(10);
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        wait_clk(2);
    endtask

    task automatic sck_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            spi_sck  = ~cfg_cpol;
            spi_mosi = ~spi_mosi;
            wait_clk(H);
            spi_sck  = cfg_cpol;
            wait_clk(H);
        end
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input bit keep);
        mi = 8'h00;
        spi_cs_n = 1'b0;
        if (!cfg_cpha) spi_mosi = mo[7];
        wait_clk(H);
        for (int i = 7; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mi[i]   = spi_miso;
                spi_sck = ~cfg_cpol;
                wait_clk(H);
                spi_sck = cfg_cpol;
                if (i > 0) spi_mosi = mo[i-1];
                wait_clk(H);
            end else begin
                spi_sck  = ~cfg_cpol;
                spi_mosi = mo[i];
                wait_clk(H);
                mi[i]   = spi_miso;
                spi_sck = cfg_cpol;
                wait_clk(H);
            end
        end
        if (!keep) begin
            spi_cs_n = 1'b1;
            wait_clk(H);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, got2;
        int n0;

        // R12 during and after reset
        wait_clk(5);
        chk(rx_valid == 1'b0, "R12 rx_valid in reset", rx_valid, 0);
        chk(spi_miso == 1'b1, "R12 miso in reset", spi_miso, 1);
        chk(tx_room == 1'b1, "R12 tx_room in reset", tx_room, 1);
        rst_n = 1'b1;
        wait_clk(5);
        chk(rx_data == 8'h00, "R12 rx_data after reset", rx_data, 0);
        chk(spi_miso == 1'b1, "R12 miso after reset", spi_miso, 1);

        // table: R1 R2, R4 (cpha0), R5 (cpha1), R3 (cpol1)
        for (int k = 0; k < 8; k++) begin
            set_mode(VEC[k][17], VEC[k][16]);
            load_tx(VEC[k][7:0]);
            n0 = vcount;
            xfer(VEC[k][15:8], got, 1'b0);
            chk(vcount == n0 + 1, $sformatf("R1 valid count vec%0d", k), vcount - n0, 1);
            chk(last_rx == VEC[k][15:8], $sformatf("R1 rx byte vec%0d", k), last_rx, VEC[k][15:8]);
            chk(got == VEC[k][7:0],
                $sformatf("%s R2 %s miso byte vec%0d", VEC[k][16] ? "R5" : "R4",
                          VEC[k][17] ? "R3" : "cpol0", k), got, VEC[k][7:0]);
        end

        // R11 empty buffer sends ones
        set_mode(1'b0, 1'b0);
        xfer(8'h3C, got, 1'b0);
        chk(got == 8'hFF, "R11 empty fill", got, 8'hFF);

        // R10 handshake, second load ignored
        load_tx(8'hA5);
        chk(tx_room == 1'b0, "R10 room after load", tx_room, 0);
        load_tx(8'h5A);
        chk(tx_room == 1'b0, "R10 room after ignored load", tx_room, 0);
        xfer(8'h11, got, 1'b0);
        chk(got == 8'hA5, "R10 first load kept", got, 8'hA5);
        chk(tx_room == 1'b1, "R10 room after take", tx_room, 1);
        xfer(8'h22, got, 1'b0);
        chk(got == 8'hFF, "R10 ignored load not sent", got, 8'hFF);

        // R6 cpha0 extra edges after byte ignored
        load_tx(8'h96);
        n0 = vcount;
        xfer(8'h69, got, 1'b1);
        sck_cycles(8);
        chk(vcount == n0 + 1, "R6 no extra valid", vcount - n0, 1);
        chk(spi_miso == 1'b1, "R6 miso idle in hold", spi_miso, 1);
        spi_cs_n = 1'b1;
        wait_clk(H);
        load_tx(8'h71);
        xfer(8'h2E, got, 1'b0);
        chk(got == 8'h71 && last_rx == 8'h2E, "R6 new byte after reselect", {got, last_rx}, 16'h712E);

        // R7 cpha1 back-to-back with select held low
        set_mode(1'b0, 1'b1);
        load_tx(8'h11);
        n0 = vcount;
        xfer(8'hC3, got, 1'b1);
        chk(last_rx == 8'hC3, "R7 first rx", last_rx, 8'hC3);
        load_tx(8'h22);
        xfer(8'h3C, got2, 1'b1);
        spi_cs_n = 1'b1;
        wait_clk(H);
        chk(vcount == n0 + 2, "R7 two valids", vcount - n0, 2);
        chk(last_rx == 8'h3C, "R7 second rx", last_rx, 8'h3C);
        chk({got, got2} == 16'h1122, "R7 miso bytes", {got, got2}, 16'h1122);

        // R9 abort mid-byte
        set_mode(1'b0, 1'b0);
        load_tx(8'h44);
        n0 = vcount;
        spi_cs_n = 1'b0;
        wait_clk(H);
        sck_cycles(3);
        spi_cs_n = 1'b1;
        wait_clk(2 * H);
        chk(vcount == n0, "R9 no valid on abort", vcount - n0, 0);
        chk(spi_miso == 1'b1, "R9 miso idle after abort", spi_miso, 1);
        load_tx(8'h66);
        xfer(8'h99, got, 1'b0);
        chk(got == 8'h66 && last_rx == 8'h99, "R9 fresh frame after abort", {got, last_rx}, 16'h6699);

        // R8 edges while deselected
        load_tx(8'h77);
        n0 = vcount;
        sck_cycles(16);
        chk(vcount == n0, "R8 no valid when deselected", vcount - n0, 0);
        chk(spi_miso == 1'b1, "R8 miso idle", spi_miso, 1);
        chk(tx_room == 1'b0, "R8 pending kept", tx_room, 0);
        xfer(8'h55, got, 1'b0);
        chk(got == 8'h77, "R8 pending sent later", got, 8'h77);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule